// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block sits between a sample source and the switch array of a segmented current-steering digital-to-analog converter. Each clock it accepts one binary sample. The low part of the sample drives binary-weighted current cells directly. The high part is turned into a thermometer code that drives a row of identical unit cells. Because every unit cell carries the same weight, a change of one step in the upper field switches exactly one cell. A wide binary switch never has to flip against all the cells below it.

All switch controls come out of one register bank clocked on the rising edge. Any difference in decode depth between the two segments is absorbed before the outputs, so every current switch changes on the same edge. A static format input selects how the sample is read. With offset binary the sample is used as it is. With two's complement the top bit is inverted before decoding, so zero lands at mid-scale.

Top module: `segdac_frontend`

## Requirements
- R1: Input bits [9:0] of `sample_in` form the binary segment and bits [13:10] form the upper field k. The upper field never affects `bin_q`, and the binary bits never affect `unit_q`.
- R2: `bin_q` equals `sample_in[9:0]` as captured at the previous rising edge. It does not depend on `twos_fmt`.
- R3: `unit_q[i]` (i = 0..14, unit enable i+1) is 1 exactly when i < k. For example, k = 4'b0110 gives `unit_q` = 15'h003F, which is enables 1 through 6.
- R4: Both output buses change only on a rising clock edge, with exactly one cycle of latency. An input change between edges is not visible at the outputs before the next edge.
- R5: Raising k by one sets exactly one more bit of `unit_q` and clears none of the bits that were set.
- R6: While `rst_n` is low, both buses are held at zero; assertion takes effect at once, without a clock. Release passes through a two-stage synchronizer, so the outputs stay zero for the two rising edges after `rst_n` goes high. The edge after those two captures the first sample.
- R7: With `twos_fmt` = 1, the upper field is decoded as k = `sample_in[13:10]` XOR 4'b1000. With `twos_fmt` = 0 it is decoded unchanged.
- R8: Half scale (k = 8) sets exactly unit enables 1 to 8 (`unit_q` = 15'h00FF). Full scale (k = 15) sets all fifteen enables (15'h7FFF). Zero (k = 0) sets none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| twos_fmt | input | 1 | 1: sample is two's complement, 0: offset binary |
| sample_in | input | 14 | Input sample |
| bin_q | output | 10 | Registered binary-weighted switch controls |
| unit_q | output | 15 | Registered thermometer enables for the unit cells |

## Verification
The bench sweeps every 14-bit code in offset-binary order. For each code it checks the one-cycle latency, the binary pass-through and the exact thermometer pattern. Against the previous code it checks that each upper-field step adds one enable and keeps the others set. This sweep would catch a decoder that is off by one or that reverses bit order, and a binary path that picks up a register stage of its own.

Directed cases cover the following:
- the 0110 example, half scale and full scale, which an off-by-one decoder gets wrong;
- both settings of the format select, where a design that inverts the wrong bit, or inverts the binary segment as well, fails;
- an input change between edges, which a transparent or unregistered path would pass straight through;
- a mid-run asynchronous reset and its two-edge release, where a synchronous-only reset or a missing synchronizer shows a sample too early.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  // Default split of the sample between binary and thermometer segments
  localparam int unsigned SEG_SAMPLE_W = 14;
  localparam int unsigned SEG_BIN_W    = 10;
  // Depth of the reset release synchronizer
  localparam int unsigned SEG_SYNC_STAGES = 2;

  // Number of unit cells for an upper field of a given width
  function automatic int unsigned unit_count(input int unsigned field_w);
    return (1 << field_w) - 1;
  endfunction
endpackage

// File: rtl/segdac_rst_sync.sv
module segdac_rst_sync #(
  parameter int unsigned STAGES = segdac_pkg::SEG_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift a one in behind the released reset
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[STAGES-1];

  // R6: the synchronized reset is never high while the raw reset is low
  p_sync_low_r6: assert property (@(posedge clk) !rst_n |-> !rst_ok)
    else $error("R6 synchronized reset high during reset");
endmodule

// File: rtl/segdac_fmt.sv
module segdac_fmt #(
  parameter int unsigned FIELD_W = 4
) (
  input  logic               twos_fmt,
  input  logic [FIELD_W-1:0] field_in,
  output logic [FIELD_W-1:0] level
);
  localparam logic [FIELD_W-1:0] SIGN_FLIP = {1'b1, {(FIELD_W-1){1'b0}}};

  // Two's complement becomes offset binary by flipping the sign bit
  always_comb begin
    if (twos_fmt) level = field_in ^ SIGN_FLIP;
    else          level = field_in;
  end
endmodule

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned UNITS  = segdac_pkg::unit_count(FIELD_W)
) (
  input  logic [FIELD_W-1:0] level,
  output logic [UNITS-1:0]   enables
);
  // Cell i turns on when the level exceeds its index
  for (genvar i = 0; i < UNITS; i++) begin : g_cell
    localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
    assign enables[i] = (level > IDX);
  end

  // R5: the code is a contiguous run of ones from bit 0
  always_comb begin
    a_therm_shape_r5: assert ((enables & (enables + 1'b1)) == '0 || $isunknown(level))
      else $error("R5 thermometer code not contiguous");
  end
endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend #(
  parameter int unsigned SAMPLE_W = segdac_pkg::SEG_SAMPLE_W,
  parameter int unsigned BIN_W    = segdac_pkg::SEG_BIN_W,
  localparam int unsigned FIELD_W = SAMPLE_W - BIN_W,
  localparam int unsigned UNITS   = segdac_pkg::unit_count(FIELD_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                twos_fmt,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [BIN_W-1:0]    bin_q,
  output logic [UNITS-1:0]    unit_q
);
  logic               rst_ok;
  logic [FIELD_W-1:0] level;
  logic [UNITS-1:0]   unit_d;
  logic [BIN_W-1:0]   bin_d;

  segdac_rst_sync #(.STAGES(segdac_pkg::SEG_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  segdac_fmt #(.FIELD_W(FIELD_W)) u_fmt (
    .twos_fmt (twos_fmt),
    .field_in (sample_in[SAMPLE_W-1:BIN_W]),
    .level    (level)
  );

  segdac_therm_dec #(.FIELD_W(FIELD_W)) u_dec (
    .level   (level),
    .enables (unit_d)
  );

  // Next state: binary segment passes straight to the register
  always_comb begin
    bin_d = sample_in[BIN_W-1:0];
  end

  // One register bank retimes both segments on the same edge
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      bin_q  <= '0;
      unit_q <= '0;
    end else begin
      bin_q  <= bin_d;
      unit_q <= unit_d;
    end
  end

  // R2: binary outputs follow the previous sample
  p_bin_pass_r2: assert property (@(posedge clk) disable iff (!rst_ok)
      $past(rst_ok) |-> bin_q == $past(sample_in[BIN_W-1:0]))
    else $error("R2 binary segment mismatch");

  // R3: enable count equals the decoded level of the previous cycle
  p_unit_count_r3: assert property (@(posedge clk) disable iff (!rst_ok)
      $past(rst_ok) |-> $countones(unit_q) == int'($past(level)))
    else $error("R3 enable count mismatch");

  // R7: in two's complement mode the level is the field with its top bit flipped
  p_twos_map_r7: assert property (@(posedge clk) disable iff (!rst_ok)
      ($past(rst_ok) && $past(twos_fmt)) |->
        $countones(unit_q) == int'($past(sample_in[SAMPLE_W-1:BIN_W]) ^ (1 << (FIELD_W-1))))
    else $error("R7 two's complement decode mismatch");

  // R6: outputs are zero while reset is applied
  p_reset_clear_r6: assert property (@(posedge clk) !rst_n |-> (bin_q == '0 && unit_q == '0))
    else $error("R6 outputs not cleared in reset");
endmodule

// File: tb/segdac_frontend_test.sv
`timescale 1ns/1ps
module segdac_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        twos_fmt;
  logic [13:0] sample_in;
  logic [9:0]  bin_q;
  logic [14:0] unit_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  segdac_frontend uut (
    .clk(clk), .rst_n(rst_n), .twos_fmt(twos_fmt),
    .sample_in(sample_in), .bin_q(bin_q), .unit_q(unit_q)
  );

  function automatic logic [14:0] therm(input int k);
    return 15'((1 << k) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the next rising edge
  task automatic step(input logic fmt, input logic [13:0] v);
    @(negedge clk);
    twos_fmt  = fmt;
    sample_in = v;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; twos_fmt = 1'b0; sample_in = 14'h3FFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset bin", 32'(bin_q), 0);
    chk("R6 reset unit", 32'(unit_q), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 release edge1", 32'(unit_q), 0);
    @(posedge clk); #1;
    chk("R6 release edge2", 32'(unit_q), 0);
    @(posedge clk); #1;
    chk("R6 first capture", 32'(unit_q), 32'(therm(15)));
    chk("R6 first capture bin", 32'(bin_q), 32'h3FF);
  endtask

  task automatic t_sweep_offset;
    logic [14:0] prev_unit = 15'h0;
    int prev_k = -1;
    for (int c = 0; c < 16384; c++) begin
      step(1'b0, 14'(c));
      chk("R2 bin pass", 32'(bin_q), 32'(c & 10'h3FF));
      chk("R3 R1 unit pattern", 32'(unit_q), 32'(therm(c >> 10)));
      if ((c >> 10) == prev_k + 1 && prev_k >= 0) begin
        chk("R5 keeps set bits", 32'(unit_q & prev_unit), 32'(prev_unit));
        chk("R5 one more bit", $countones(unit_q), $countones(prev_unit) + 1);
      end
      prev_k = c >> 10;
      prev_unit = unit_q;
    end
  endtask

  task automatic t_points;
    step(1'b0, {4'b0110, 10'h2A5});
    chk("R3 example 0110", 32'(unit_q), 32'h003F);
    step(1'b0, {4'b1000, 10'h000});
    chk("R8 half scale", 32'(unit_q), 32'h00FF);
    step(1'b0, {4'b1111, 10'h000});
    chk("R8 full scale", 32'(unit_q), 32'h7FFF);
    step(1'b0, {4'b0000, 10'h3FF});
    chk("R8 zero", 32'(unit_q), 32'h0000);
    chk("R1 upper field no effect on bin", 32'(bin_q), 32'h3FF);
  endtask

  task automatic t_twos;
    for (int k = 0; k < 16; k++) begin
      step(1'b1, {4'(k), 10'h155});
      chk("R7 twos decode", 32'(unit_q), 32'(therm(k ^ 8)));
      chk("R2 bin unaffected by format", 32'(bin_q), 32'h155);
    end
    step(1'b1, 14'h2000);
    chk("R7 most negative", 32'(unit_q), 32'h0000);
    step(1'b1, 14'h0000);
    chk("R7 zero at mid-scale", 32'(unit_q), 32'h00FF);
  endtask

  task automatic t_hold;
    step(1'b0, {4'b0011, 10'h00F});
    @(negedge clk);
    sample_in = {4'b1100, 10'h3F0};
    #1;
    chk("R4 unit held between edges", 32'(unit_q), 32'(therm(3)));
    chk("R4 bin held between edges", 32'(bin_q), 32'h00F);
    @(posedge clk); #1;
    chk("R4 unit after edge", 32'(unit_q), 32'(therm(12)));
    chk("R4 bin after edge", 32'(bin_q), 32'h3F0);
  endtask

  task automatic t_async_reset;
    step(1'b0, 14'h3ABC);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk("R6 async clear unit", 32'(unit_q), 0);
    chk("R6 async clear bin", 32'(bin_q), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 sync release 1", 32'(bin_q), 0);
    @(posedge clk); #1;
    chk("R6 sync release 2", 32'(bin_q), 0);
    @(posedge clk); #1;
    chk("R6 resume", 32'(bin_q), 32'h2BC);
  endtask

  initial begin
    t_reset();
    t_sweep_offset();
    t_points();
    t_twos();
    t_hold();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule